// File: doc/BRIEF.md
# Receive Gain Controller for an RFID Reader

This block sets the 3-bit gain code of a reader's receive amplifier. It reads two comparator flags. The first says the received envelope is above the attack threshold. The second says it is above the decay threshold. It also reads a set of static mode inputs and a strobe that marks the start of a receive window. Gain code 0 means maximum gain. Code bit 0, bit 1 and bit 2 each add roughly 5.7 dB, 11.4 dB and 22.8 dB of attenuation, which gives eight steps over about 40 dB.

At the start of a window the gain returns to maximum. A strong signal then walks the gain down one step per attack period, and the period is chosen by a rate code. While the signal is between the two thresholds the gain stays where it is. When the signal stays below the decay threshold for a chosen silence time, the gain either jumps back to maximum (fast mode) or climbs back one step per silence period (slow mode). An optional mode leaves the first pulse of each burst unattacked, so that a DC shift can settle first. A burst starts at a window start or after a full silence time.

All periods are parameters given in clock cycles. When automatic control is off, the gain code comes straight from a fixed code input.

Top module: `rx_agc_ctrl`

## Requirements
- R1: After reset, and one cycle after `win_start` is sampled high, `gain_code` is 0 (maximum gain) while `agc_en` is 1.
- R2: While `agc_en` is 0, `gain_code` equals `fixed_gain`. Automatic control then starts again from code 0 when it is re-enabled.
- R3: While `above_attack` stays high, the code rises by one every P cycles. P is ATK_CYC0, ATK_CYC1 or ATK_CYC2 for `attack_rate` 0, 1 or 2, and rate 3 behaves as rate 2.
- R4: The code saturates at 7 and never wraps around to 0 under attack.
- R5: While `above_decay` is high and `above_attack` is low, the code does not change.
- R6: With `slow_decay` 0, the code returns to 0 after W consecutive cycles with `above_decay` low. W is WAIT_CYC0, WAIT_CYC1 or WAIT_CYC2 for `decay_wait` 0, 1 or 2, and wait code 3 behaves as 2.
- R7: With `slow_decay` 1, the code falls by one after every W consecutive cycles with `above_decay` low, and it stops at 0.
- R8: With `skip_first` 1, attack is suppressed from the start of a burst until `above_decay` first falls. A burst starts at a window start or after W silent cycles.
- R9: The attack period counter restarts whenever `above_attack` drops, so interrupted runs shorter than P never step the gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agc_en | input | 1 | Automatic gain control on |
| fixed_gain | input | 3 | Gain code used when control is off |
| attack_rate | input | 2 | Attack period select |
| decay_wait | input | 2 | Silence period select |
| slow_decay | input | 1 | 1: step back one code per period, 0: jump to max gain |
| skip_first | input | 1 | Do not attack the first pulse of a burst |
| win_start | input | 1 | Receive window start strobe |
| above_attack | input | 1 | Envelope above attack threshold |
| above_decay | input | 1 | Envelope above decay threshold |
| gain_code | output | 3 | Amplifier attenuation code, 0 = maximum gain |

## Verification
Every gain change is registered once. A change due on the Nth rising edge of a condition is therefore visible just after that edge. The fixed-gain path is combinational and shows up at once. The bench drives inputs on falling edges and samples `gain_code` on the falling edge right after the edge where the change is due. It also samples one edge earlier to confirm that nothing changed too soon. Periods are counted from the first edge that sees the condition, so a run of N edges at attack period P is expected to give floor(N/P) steps, capped at 7.

// File: rtl/rx_agc_ctrl.sv
module rx_agc_ctrl #(
  parameter int ATK_CYC0  = 8,
  parameter int ATK_CYC1  = 16,
  parameter int ATK_CYC2  = 32,
  parameter int WAIT_CYC0 = 12,
  parameter int WAIT_CYC1 = 24,
  parameter int WAIT_CYC2 = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       agc_en,
  input  logic [2:0] fixed_gain,
  input  logic [1:0] attack_rate,
  input  logic [1:0] decay_wait,
  input  logic       slow_decay,
  input  logic       skip_first,
  input  logic       win_start,
  input  logic       above_attack,
  input  logic       above_decay,
  output logic [2:0] gain_code
);
  localparam int MA  = (ATK_CYC0 > ATK_CYC1) ? ATK_CYC0 : ATK_CYC1;
  localparam int MB  = (MA > ATK_CYC2) ? MA : ATK_CYC2;
  localparam int MC  = (WAIT_CYC0 > WAIT_CYC1) ? WAIT_CYC0 : WAIT_CYC1;
  localparam int MD  = (MC > WAIT_CYC2) ? MC : WAIT_CYC2;
  localparam int MAXC = (MB > MD) ? MB : MD;
  localparam int CW  = $clog2(MAXC + 1);

  logic [2:0]    atten;
  logic [CW-1:0] atk_cnt, quiet_cnt, atk_lim, wait_lim;
  logic          armed, prev_dec;
  logic          atk_ok, atk_hit, quiet_hit;

  always_comb begin
    case (attack_rate)
      2'd0:    atk_lim = CW'(ATK_CYC0 - 1);
      2'd1:    atk_lim = CW'(ATK_CYC1 - 1);
      default: atk_lim = CW'(ATK_CYC2 - 1);
    endcase
    case (decay_wait)
      2'd0:    wait_lim = CW'(WAIT_CYC0 - 1);
      2'd1:    wait_lim = CW'(WAIT_CYC1 - 1);
      default: wait_lim = CW'(WAIT_CYC2 - 1);
    endcase
  end

  assign atk_ok    = above_attack && !(skip_first && armed);
  assign atk_hit   = atk_ok && (atk_cnt == atk_lim);
  assign quiet_hit = !above_decay && (quiet_cnt == wait_lim);
  assign gain_code = agc_en ? atten : fixed_gain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      atten     <= '0;
      atk_cnt   <= '0;
      quiet_cnt <= '0;
      armed     <= 1'b1;
      prev_dec  <= 1'b0;
    end else begin
      prev_dec <= above_decay;
      if (!agc_en || win_start) begin
        atten     <= '0;
        atk_cnt   <= '0;
        quiet_cnt <= '0;
        armed     <= 1'b1;
      end else begin
        atk_cnt   <= (atk_ok && !atk_hit) ? atk_cnt + 1'b1 : '0;
        quiet_cnt <= (!above_decay && !quiet_hit) ? quiet_cnt + 1'b1 : '0;
        if (quiet_hit)
          armed <= 1'b1;
        else if (prev_dec && !above_decay)
          armed <= 1'b0;
        if (atk_hit) begin
          if (atten != 3'd7) atten <= atten + 3'd1;
        end else if (quiet_hit) begin
          if (!slow_decay)         atten <= '0;
          else if (atten != 3'd0)  atten <= atten - 3'd1;
        end
      end
    end
  end

  // R1
  win_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> atten == 3'd0);
  // R2
  dis_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !agc_en |=> atten == 3'd0);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agc_en && !win_start && above_decay && !above_attack |=> atten == $past(atten));
  // R4
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agc_en && !win_start && atten == 3'd7 && above_attack && above_decay |=> atten == 3'd7);
  // R7
  slow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agc_en && !win_start && slow_decay && !above_attack
      |=> ($past(atten) == atten) || ($past(atten) == atten + 3'd1));
  // R8
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agc_en && !win_start && skip_first && armed |=> !(atten > $past(atten)));
endmodule

// File: tb/rx_agc_ctrl_tb_top.sv
`timescale 1ns/100ps
module rx_agc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       agc_en = 1'b1;
  logic [2:0] fixed_gain = 3'd0;
  logic [1:0] attack_rate = 2'd0;
  logic [1:0] decay_wait = 2'd0;
  logic       slow_decay = 1'b0;
  logic       skip_first = 1'b0;
  logic       win_start = 1'b0;
  logic       above_attack = 1'b0;
  logic       above_decay = 1'b1;
  logic [2:0] gain_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rx_agc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .agc_en(agc_en), .fixed_gain(fixed_gain),
    .attack_rate(attack_rate), .decay_wait(decay_wait), .slow_decay(slow_decay),
    .skip_first(skip_first), .win_start(win_start), .above_attack(above_attack),
    .above_decay(above_decay), .gain_code(gain_code)
  );

  // {attack_rate, edges with above_attack high, expected code}
  localparam logic [12:0] VEC [0:8] = '{
    {2'd0, 8'd8,   3'd1}, {2'd0, 8'd7,  3'd0}, {2'd0, 8'd20, 3'd2},
    {2'd0, 8'd100, 3'd7}, {2'd1, 8'd16, 3'd1}, {2'd1, 8'd47, 3'd2},
    {2'd2, 8'd64,  3'd2}, {2'd3, 8'd64, 3'd2}, {2'd3, 8'd31, 3'd0}
  };

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gain_code=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic window();
    win_start = 1'b1; above_attack = 1'b0; above_decay = 1'b1;
    run(1);
    win_start = 1'b0;
  endtask

  task automatic attack(input int n);
    above_attack = 1'b1; above_decay = 1'b1;
    run(n);
    above_attack = 1'b0;
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    run(1);
    check("R1 reset", gain_code, 3'd0);

    for (int i = 0; i < 9; i++) begin
      attack_rate = VEC[i][12:11];
      window();
      attack(int'(VEC[i][10:3]));
      check(VEC[i][2:0] == 3'd7 ? "R4 saturate" : "R3 attack rate", gain_code, VEC[i][2:0]);
      run(10);
      check("R5 hold", gain_code, VEC[i][2:0]);
    end

    window();
    check("R1 window start", gain_code, 3'd0);

    // R2 bypass and restart
    attack_rate = 2'd0;
    attack(24);
    agc_en = 1'b0; fixed_gain = 3'd5;
    #1 check("R2 fixed code", gain_code, 3'd5);
    run(2);
    agc_en = 1'b1;
    #1 check("R2 restart at max", gain_code, 3'd0);

    // R6 fast decay
    window(); attack(24);
    above_decay = 1'b0; decay_wait = 2'd0;
    run(11); check("R6 before wait", gain_code, 3'd3);
    run(1);  check("R6 fast decay", gain_code, 3'd0);
    window(); attack(24);
    above_decay = 1'b0; decay_wait = 2'd3;
    run(47); check("R6 wait code 3 early", gain_code, 3'd3);
    run(1);  check("R6 wait code 3", gain_code, 3'd0);

    // R7 slow decay
    window(); attack(24);
    slow_decay = 1'b1; decay_wait = 2'd1; above_decay = 1'b0;
    run(23); check("R7 before step", gain_code, 3'd3);
    run(1);  check("R7 step 1", gain_code, 3'd2);
    run(24); check("R7 step 2", gain_code, 3'd1);
    run(24); check("R7 step 3", gain_code, 3'd0);
    run(24); check("R7 floor", gain_code, 3'd0);
    slow_decay = 1'b0; decay_wait = 2'd0;

    // R8 first pulse not attacked
    skip_first = 1'b1;
    window(); attack(20);
    check("R8 first pulse", gain_code, 3'd0);
    above_decay = 1'b0; run(3);
    attack(8);
    check("R8 second pulse", gain_code, 3'd1);
    above_decay = 1'b0; run(12);
    check("R8 burst end", gain_code, 3'd0);
    attack(16);
    check("R8 new burst", gain_code, 3'd0);
    skip_first = 1'b0;

    // R9 interrupted attack
    window(); attack(7); run(1); attack(7);
    check("R9 restart count", gain_code, 3'd0);
    attack(1);
    check("R9 full period", gain_code, 3'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule